// File: doc/BRIEF.md
# Host Command Front-End

This block sits on the host side of a fixed-disk adapter and takes in everything the host writes to set up work. Three write ports feed it: an 8-bit control byte, an 8-bit attention byte that names a target (the adapter itself or one of two drives) together with a request, and a 16-bit command port that takes the words of a command one at a time.

An attention byte asking for a command opens a collection window for the named target. The command port then takes either two or four words. Bit 14 of the first word selects the longer form. When the last word arrives, the device field of the first word is compared with the target named by the attention byte. On a match, the command code and words are held for the sequencer, and a start pulse follows after a programmable delay. On a mismatch, the command is refused and an error is flagged.

An end-of-interrupt request is passed on as a pulse. A reset can be requested in two ways: a reset attention to the adapter, or the control byte's top bit being released from 1 to 0. Either one forces the busy state, abandons any collection or pending command, and reports reset completion after a delay that is a fixed multiple of the command delay. Malformed host writes are ignored and reported on a one-cycle error pulse with a code.

Top module: `hostcmd_front`

## Requirements
- R1: After synchronous reset, ctrl_q is 0, busy and collecting are 0, and cmd_start, reset_done, eoi_pulse and err_pulse are 0.
- R2: An attention byte is decoded as follows. Bits 7:5 name the target: 7 is the adapter, 0 is drive 0, 1 is drive 1. Bit 4 must be 0. Bits 3:0 give the request: 1 is command, 2 is end-of-interrupt, 4 is reset. A command request while nothing is being collected sets busy and collecting on the next cycle, latches the target on cmd_dev, and clears all four command words to 0.
- R3: A command request that arrives while collecting is ignored (cmd_dev is kept). On the next cycle it raises err_pulse with err_code 1.
- R4: Command words fill positions 0 to 3 in order, with word i on cmd_words[16*i+15:16*i]. Collection ends after 4 words if bit 14 of word 0 is 1, and after 2 words otherwise. collecting falls in the cycle after the last word is written.
- R5: When the device field (bits 7:5) of word 0 matches cmd_dev, the command is accepted. cmd_code takes bits 4:0 of word 0 on the next cycle. busy stays 1, and cmd_start pulses for one cycle exactly CMD_DELAY cycles after the last word's write edge. busy falls on that same edge.
- R6: When the device field of word 0 differs from cmd_dev, the command is rejected. On the next cycle err_pulse rises with err_code 2, busy and collecting are 0, and no cmd_start follows.
- R7: A command-port write while not collecting (for example a fifth word) leaves cmd_words unchanged and raises err_pulse with err_code 3 on the next cycle.
- R8: A legal end-of-interrupt request gives a one-cycle eoi_pulse on the next cycle, with eoi_dev set to the target. It leaves busy and collecting unchanged.
- R9: A reset request takes effect on the next cycle: busy is 1, collecting is 0, and any pending start is cancelled. A reset request is either an adapter reset attention, or a control write that takes bit 7 of ctrl_q from 1 to 0. reset_done then pulses exactly CMD_DELAY*RST_MULT cycles after the request edge, and busy falls on that edge.
- R10: ctrl_q holds the last control byte written. A control write that does not take bit 7 from 1 to 0 starts no reset.
- R11: An attention byte is illegal if it has any of the following: a target of 2 to 6, bit 4 set, a request code other than 1, 2 or 4, or a reset request sent to a drive. An illegal byte changes no state and raises err_pulse with err_code 4 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte |
| attn_we | input | 1 | Attention byte write strobe |
| attn_wdata | input | 8 | Attention byte |
| cir_we | input | 1 | Command word write strobe |
| cir_wdata | input | 16 | Command word |
| ctrl_q | output | 8 | Current control byte |
| busy | output | 1 | Busy status |
| collecting | output | 1 | Command words being gathered |
| cmd_dev | output | 3 | Target latched from the last command attention |
| cmd_code | output | 5 | Code of the last accepted command |
| cmd_words | output | 64 | Gathered command words, word i at bits 16*i+15:16*i |
| cmd_start | output | 1 | One-cycle sequencer start |
| eoi_pulse | output | 1 | One-cycle end-of-interrupt |
| eoi_dev | output | 3 | Target of the end-of-interrupt |
| reset_done | output | 1 | One-cycle reset completion |
| err_pulse | output | 1 | One-cycle error flag |
| err_code | output | 3 | 1 overlap, 2 device mismatch, 3 stray word, 4 illegal attention |

## Verification
The bound checker watches the single-step reactions on every cycle: the reset state, the response to a command request (whether the block is idle or already collecting), illegal attention bytes, stray command words leaving the words untouched, end-of-interrupt pulses, and the busy state forced by a control release. Only the bench's scenarios can show the rest, because it depends on long timed windows or on counting words: the exact start and reset-completion latencies, the choice between 2-word and 4-word commands, cancellation of a pending start by a reset, and refusal on a device mismatch. Random commands with random targets, lengths and occasional mismatches check code and word capture against values the bench computes.

// File: rtl/hostcmd_pkg.sv
package hostcmd_pkg;

    localparam int WORD_W  = 16;
    localparam int N_LONG  = 4;
    localparam int N_SHORT = 2;
    localparam int LEN_BIT = 14;
    localparam int DEV_W   = 3;
    localparam int CODE_W  = 5;
    localparam int DEV_LSB = 5;

    localparam logic [DEV_W-1:0] DEV_ADAPTER = 3'd7;
    localparam logic [DEV_W-1:0] DEV_DRIVE0  = 3'd0;
    localparam logic [DEV_W-1:0] DEV_DRIVE1  = 3'd1;

    typedef enum logic [1:0] {
        REQ_NONE  = 2'd0,
        REQ_CMD   = 2'd1,
        REQ_EOI   = 2'd2,
        REQ_RESET = 2'd3
    } req_e;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_OVERLAP  = 3'd1,
        ERR_MISMATCH = 3'd2,
        ERR_EXTRA    = 3'd3,
        ERR_BADATTN  = 3'd4
    } err_e;

    typedef struct packed {
        logic             ok;
        req_e             req;
        logic [DEV_W-1:0] dev;
    } attn_t;

    function automatic logic dev_known(input logic [DEV_W-1:0] d);
        return (d == DEV_ADAPTER) || (d == DEV_DRIVE0) || (d == DEV_DRIVE1);
    endfunction

endpackage

// File: rtl/hostcmd_attn_dec.sv
module hostcmd_attn_dec
    import hostcmd_pkg::*;
(
    input  logic [7:0] byte_in,
    output attn_t      attn
);
    logic [DEV_W-1:0] tgt;
    logic [3:0]       code;

    assign tgt  = byte_in[7:5];
    assign code = byte_in[3:0];

    always_comb begin
        attn.dev = tgt;
        attn.req = REQ_NONE;
        case (code)
            4'd1:    attn.req = REQ_CMD;
            4'd2:    attn.req = REQ_EOI;
            4'd4:    attn.req = REQ_RESET;
            default: attn.req = REQ_NONE;
        endcase
        attn.ok = dev_known(tgt) && !byte_in[4] && (attn.req != REQ_NONE)
                  && !((attn.req == REQ_RESET) && (tgt != DEV_ADAPTER));
    end
endmodule

// File: rtl/hostcmd_collect.sv
module hostcmd_collect
    import hostcmd_pkg::*;
#(
    parameter int W      = WORD_W,
    parameter int NL     = N_LONG,
    parameter int NS     = N_SHORT,
    parameter int LBIT   = LEN_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open,
    input  logic              abort,
    input  logic              wr,
    input  logic [W-1:0]      wdata,
    output logic              active,
    output logic              last,
    output logic [NL*W-1:0]   words,
    output logic [DEV_W-1:0]  w0_dev,
    output logic [CODE_W-1:0] w0_code
);
    localparam int PW = $clog2(NL);

    logic [W-1:0]  slot [NL];
    logic [PW-1:0] pos;
    logic          long_form;

    assign long_form = (pos == '0) ? wdata[LBIT] : slot[0][LBIT];
    assign last      = active && wr &&
                       (pos == (long_form ? PW'(NL - 1) : PW'(NS - 1)));
    assign w0_dev    = slot[0][DEV_LSB +: DEV_W];
    assign w0_code   = slot[0][CODE_W-1:0];

    for (genvar i = 0; i < NL; i++) begin : g_out
        assign words[i*W +: W] = slot[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            pos    <= '0;
            for (int i = 0; i < NL; i++) slot[i] <= '0;
        end else if (abort) begin
            active <= 1'b0;
        end else if (open) begin
            active <= 1'b1;
            pos    <= '0;
            for (int i = 0; i < NL; i++) slot[i] <= '0;
        end else if (wr && active) begin
            slot[pos] <= wdata;
            pos       <= pos + 1'b1;
            if (last) active <= 1'b0;
        end
    end
endmodule

// File: rtl/hostcmd_timer.sv
module hostcmd_timer #(
    parameter int CMD_DELAY = 2000,
    parameter int RST_MULT  = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic start_cmd,
    input  logic start_rst,
    output logic pend_cmd,
    output logic exp_cmd,
    output logic exp_rst,
    output logic done_cmd,
    output logic done_rst
);
    localparam int RST_CYC = CMD_DELAY * RST_MULT;
    localparam int CW      = $clog2(RST_CYC + 1);

    logic          active;
    logic          is_rst;
    logic [CW-1:0] cnt;
    logic          exp_any;

    assign exp_any  = active && (cnt == CW'(1));
    assign exp_cmd  = exp_any && !is_rst;
    assign exp_rst  = exp_any && is_rst;
    assign pend_cmd = active && !is_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            is_rst   <= 1'b0;
            cnt      <= '0;
            done_cmd <= 1'b0;
            done_rst <= 1'b0;
        end else begin
            done_cmd <= 1'b0;
            done_rst <= 1'b0;
            if (start_rst) begin
                active <= 1'b1;
                is_rst <= 1'b1;
                cnt    <= CW'(RST_CYC);
            end else if (start_cmd) begin
                active <= 1'b1;
                is_rst <= 1'b0;
                cnt    <= CW'(CMD_DELAY);
            end else if (exp_any) begin
                active   <= 1'b0;
                done_cmd <= !is_rst;
                done_rst <= is_rst;
            end else if (active) begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/hostcmd_front.sv
module hostcmd_front
    import hostcmd_pkg::*;
#(
    parameter int CMD_DELAY = 2000,
    parameter int RST_MULT  = 50
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctrl_we,
    input  logic [7:0]           ctrl_wdata,
    input  logic                 attn_we,
    input  logic [7:0]           attn_wdata,
    input  logic                 cir_we,
    input  logic [WORD_W-1:0]    cir_wdata,
    output logic [7:0]           ctrl_q,
    output logic                 busy,
    output logic                 collecting,
    output logic [DEV_W-1:0]     cmd_dev,
    output logic [CODE_W-1:0]    cmd_code,
    output logic [N_LONG*WORD_W-1:0] cmd_words,
    output logic                 cmd_start,
    output logic                 eoi_pulse,
    output logic [DEV_W-1:0]     eoi_dev,
    output logic                 reset_done,
    output logic                 err_pulse,
    output logic [2:0]           err_code
);
    attn_t             attn;
    logic              coll_last;
    logic [DEV_W-1:0]  w0_dev;
    logic [CODE_W-1:0] w0_code;
    logic              pend_cmd, exp_cmd, exp_rst;
    logic              ev_rst, a_cmd, open, accept, reject;
    logic              busy_n;
    err_e              err_n;

    hostcmd_attn_dec u_dec (
        .byte_in (attn_wdata),
        .attn    (attn)
    );

    hostcmd_collect u_coll (
        .clk     (clk),
        .rst     (rst),
        .open    (open),
        .abort   (ev_rst),
        .wr      (cir_we),
        .wdata   (cir_wdata),
        .active  (collecting),
        .last    (coll_last),
        .words   (cmd_words),
        .w0_dev  (w0_dev),
        .w0_code (w0_code)
    );

    hostcmd_timer #(.CMD_DELAY(CMD_DELAY), .RST_MULT(RST_MULT)) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .start_cmd (accept),
        .start_rst (ev_rst),
        .pend_cmd  (pend_cmd),
        .exp_cmd   (exp_cmd),
        .exp_rst   (exp_rst),
        .done_cmd  (cmd_start),
        .done_rst  (reset_done)
    );

    always_comb begin
        ev_rst = (ctrl_we && ctrl_q[7] && !ctrl_wdata[7]) ||
                 (attn_we && attn.ok && (attn.req == REQ_RESET));
        a_cmd  = attn_we && attn.ok && (attn.req == REQ_CMD);
        open   = a_cmd && !collecting && !ev_rst;
        accept = coll_last && (w0_dev == cmd_dev) && !ev_rst;
        reject = coll_last && (w0_dev != cmd_dev);

        err_n = ERR_NONE;
        if (attn_we && !attn.ok)           err_n = ERR_BADATTN;
        else if (a_cmd && collecting)      err_n = ERR_OVERLAP;
        else if (reject)                   err_n = ERR_MISMATCH;
        else if (cir_we && !collecting)    err_n = ERR_EXTRA;

        busy_n = busy;
        if (exp_cmd || exp_rst) busy_n = collecting;
        if (reject)             busy_n = pend_cmd && !exp_cmd;
        if (open || accept || ev_rst) busy_n = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            busy      <= 1'b0;
            cmd_dev   <= '0;
            cmd_code  <= '0;
            eoi_pulse <= 1'b0;
            eoi_dev   <= '0;
            err_pulse <= 1'b0;
            err_code  <= ERR_NONE;
        end else begin
            busy      <= busy_n;
            err_pulse <= (err_n != ERR_NONE);
            err_code  <= err_n;
            eoi_pulse <= attn_we && attn.ok && (attn.req == REQ_EOI);
            if (attn_we && attn.ok && (attn.req == REQ_EOI)) eoi_dev <= attn.dev;
            if (ctrl_we) ctrl_q   <= ctrl_wdata;
            if (open)    cmd_dev  <= attn.dev;
            if (accept)  cmd_code <= w0_code;
        end
    end
endmodule

// File: rtl/hostcmd_front_chk.sv
module hostcmd_front_chk (
    input logic        clk,
    input logic        rst,
    input logic        ctrl_we,
    input logic [7:0]  ctrl_wdata,
    input logic [7:0]  ctrl_q,
    input logic        attn_we,
    input logic [7:0]  attn_wdata,
    input logic        cir_we,
    input logic        busy,
    input logic        collecting,
    input logic [63:0] cmd_words,
    input logic        cmd_start,
    input logic        eoi_pulse,
    input logic        reset_done,
    input logic        err_pulse,
    input logic [2:0]  err_code
);
    logic tgt_ok, cmd_req, eoi_req;
    assign tgt_ok  = (attn_wdata[7:5] == 3'd7) || (attn_wdata[7:5] <= 3'd1);
    assign cmd_req = attn_we && tgt_ok && !attn_wdata[4] && (attn_wdata[3:0] == 4'd1);
    assign eoi_req = attn_we && tgt_ok && !attn_wdata[4] && (attn_wdata[3:0] == 4'd2);

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!busy && !collecting && ctrl_q == 8'h00 && !cmd_start && !err_pulse));

    // R2
    a_r2_cmd_open: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && !collecting && !ctrl_we) |=> (busy && collecting));

    // R3
    a_r3_overlap_flag: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && collecting && !ctrl_we) |=> (err_pulse && err_code == 3'd1 && collecting));

    // R5
    a_r5_start_alone: assert property (@(posedge clk) disable iff (rst)
        cmd_start |-> (!reset_done && $past(busy)));

    // R7
    a_r7_stray_word: assert property (@(posedge clk) disable iff (rst)
        (cir_we && !collecting && !attn_we && !ctrl_we) |=>
            (err_pulse && err_code == 3'd3 && $stable(cmd_words)));

    // R8
    a_r8_eoi_pulse: assert property (@(posedge clk) disable iff (rst)
        eoi_req |=> eoi_pulse);

    // R9
    a_r9_release_busy: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && ctrl_q[7] && !ctrl_wdata[7]) |=> (busy && !collecting && !cmd_start));

    // R11
    a_r11_bad_target: assert property (@(posedge clk) disable iff (rst)
        (attn_we && !tgt_ok) |=> (err_pulse && err_code == 3'd4));
endmodule

bind hostcmd_front hostcmd_front_chk u_chk (.*);

// File: tb/hostcmd_front_tb.sv
`timescale 1ns/1ps
module hostcmd_front_tb;
    localparam int D   = 3;
    localparam int RM  = 5;
    localparam int RST = D * RM;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we = 1'b0, attn_we = 1'b0, cir_we = 1'b0;
    logic [7:0]  ctrl_wdata = '0, attn_wdata = '0;
    logic [15:0] cir_wdata = '0;
    logic [7:0]  ctrl_q;
    logic        busy, collecting, cmd_start, eoi_pulse, reset_done, err_pulse;
    logic [2:0]  cmd_dev, eoi_dev, err_code;
    logic [4:0]  cmd_code;
    logic [63:0] cmd_words;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    hostcmd_front #(.CMD_DELAY(D), .RST_MULT(RM)) u_dut (
        .clk(clk), .rst(rst),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .attn_we(attn_we), .attn_wdata(attn_wdata),
        .cir_we(cir_we), .cir_wdata(cir_wdata),
        .ctrl_q(ctrl_q), .busy(busy), .collecting(collecting),
        .cmd_dev(cmd_dev), .cmd_code(cmd_code), .cmd_words(cmd_words),
        .cmd_start(cmd_start), .eoi_pulse(eoi_pulse), .eoi_dev(eoi_dev),
        .reset_done(reset_done), .err_pulse(err_pulse), .err_code(err_code)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_ctrl(input logic [7:0] b);
        ctrl_wdata = b; ctrl_we = 1'b1;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic put_attn(input logic [7:0] b);
        attn_wdata = b; attn_we = 1'b1;
        @(negedge clk); attn_we = 1'b0;
    endtask

    task automatic put_word(input logic [15:0] w);
        cir_wdata = w; cir_we = 1'b1;
        @(negedge clk); cir_we = 1'b0;
    endtask

    function automatic logic [63:0] pack_words(input logic [15:0] w0, w1, w2, w3, input bit lng);
        return lng ? {w3, w2, w1, w0} : {32'h0, w1, w0};
    endfunction

    // after the last word: start exactly D cycles later, busy falls with it
    task automatic expect_start(input string tag, input logic [4:0] code, input logic [63:0] words);
        repeat (D - 1) @(negedge clk);
        chk({tag, " busy before start"}, {cmd_start, busy}, 2'b01);
        @(negedge clk);
        chk({tag, " start pulse"}, {cmd_start, busy}, 2'b10);
        chk({tag, " code"}, cmd_code, code);
        chk({tag, " words"}, cmd_words, words);
    endtask

    task automatic expect_no_start(input string tag, input int cycles);
        bit seen = 1'b0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (cmd_start) seen = 1'b1;
        end
        chk(tag, seen, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D5E));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 ctrl_q", ctrl_q, 8'h00);
        chk("R1 busy/collecting", {busy, collecting}, 2'b00);
        chk("R1 pulses", {cmd_start, reset_done, eoi_pulse, err_pulse}, 4'b0000);

        // R10 control register, no reset without a 1->0 release
        put_ctrl(8'h03);
        chk("R10 ctrl_q", ctrl_q, 8'h03);
        put_ctrl(8'h83);
        chk("R10 set bit7 no busy", {ctrl_q, busy}, {8'h83, 1'b0});
        put_ctrl(8'h81);
        chk("R10 keep bit7 no busy", busy, 1'b0);

        // R9 release of control bit 7
        put_ctrl(8'h01);
        chk("R9 release busy", {busy, collecting}, 2'b10);
        repeat (RST - 1) @(negedge clk);
        chk("R9 before done", {reset_done, busy}, 2'b01);
        @(negedge clk);
        chk("R9 reset_done", {reset_done, busy}, 2'b10);

        // R2 command attention to adapter
        put_attn(8'hE1);
        chk("R2 open", {busy, collecting, cmd_dev}, {2'b11, 3'd7});
        chk("R2 words cleared", cmd_words, 64'h0);
        // R3 overlap
        put_attn(8'h01);
        chk("R3 overlap err", {err_pulse, err_code}, {1'b1, 3'd1});
        chk("R3 dev kept", {cmd_dev, collecting}, {3'd7, 1'b1});

        // R4/R5 short command
        put_word(16'h00F2);
        chk("R4 still collecting", collecting, 1'b1);
        put_word(16'h1234);
        chk("R4 short ends", collecting, 1'b0);
        expect_start("R5 short", 5'h12, pack_words(16'h00F2, 16'h1234, 0, 0, 1'b0));

        // R7 stray word
        put_word(16'hBEEF);
        chk("R7 stray err", {err_pulse, err_code}, {1'b1, 3'd3});
        chk("R7 words unchanged", cmd_words, pack_words(16'h00F2, 16'h1234, 0, 0, 1'b0));

        // R4/R5 long command to drive 1
        put_attn(8'h21);
        put_word(16'h4021);
        put_word(16'h0005);
        chk("R4 long continues", collecting, 1'b1);
        put_word(16'h1000);
        put_word(16'h0002);
        chk("R4 long ends", collecting, 1'b0);
        expect_start("R5 long", 5'h01, {16'h0002, 16'h1000, 16'h0005, 16'h4021});

        // R6 mismatch
        put_attn(8'h01);
        put_word(16'h0021);
        put_word(16'h0008);
        chk("R6 mismatch err", {err_pulse, err_code}, {1'b1, 3'd2});
        chk("R6 idle", {busy, collecting}, 2'b00);
        expect_no_start("R6 no start", D + 2);

        // R8 end-of-interrupt
        put_attn(8'h02);
        chk("R8 eoi drive0", {eoi_pulse, eoi_dev, busy}, {1'b1, 3'd0, 1'b0});
        put_attn(8'h22);
        chk("R8 eoi drive1", {eoi_pulse, eoi_dev}, {1'b1, 3'd1});

        // R11 illegal attention bytes
        put_attn(8'h41);
        chk("R11 target 2", {err_pulse, err_code, collecting}, {1'b1, 3'd4, 1'b0});
        put_attn(8'h04);
        chk("R11 reset to drive", {err_pulse, err_code, busy}, {1'b1, 3'd4, 1'b0});
        put_attn(8'hE3);
        chk("R11 bad code", {err_pulse, err_code}, {1'b1, 3'd4});
        put_attn(8'hF1);
        chk("R11 bit4 set", {err_pulse, err_code, collecting}, {1'b1, 3'd4, 1'b0});

        // R9 reset attention aborts collection
        put_attn(8'hE1);
        put_word(16'h00E5);
        put_attn(8'hE4);
        chk("R9 attn reset", {busy, collecting}, 2'b10);
        repeat (RST - 1) @(negedge clk);
        chk("R9 attn before done", reset_done, 1'b0);
        @(negedge clk);
        chk("R9 attn done", {reset_done, busy}, 2'b10);
        put_word(16'h0001);
        chk("R9 collection aborted", {err_pulse, err_code}, {1'b1, 3'd3});

        // R9 reset cancels a pending start
        put_attn(8'hE1);
        put_word(16'h00E5);
        put_word(16'h0000);
        put_attn(8'hE4);
        expect_no_start("R9 start cancelled", RST + 2);

        // random commands: R2 R4 R5 R6 R8
        for (int i = 0; i < 40; i++) begin
            logic [2:0]  dv, wdv;
            logic [15:0] w0, w1, w2, w3;
            bit lng, bad;
            case ($urandom % 3)
                0: dv = 3'd7;
                1: dv = 3'd0;
                default: dv = 3'd1;
            endcase
            lng = ($urandom % 2) == 1;
            bad = ($urandom % 5) == 0;
            wdv = bad ? ((dv == 3'd7) ? 3'd0 : 3'd7) : dv;
            w0  = 16'($urandom);
            w0[14] = lng;
            w0[7:5] = wdv;
            w1 = 16'($urandom); w2 = 16'($urandom); w3 = 16'($urandom);
            if ($urandom % 4 == 0) begin
                put_attn({dv, 5'h02});
                chk("R8 rnd eoi", {eoi_pulse, eoi_dev}, {1'b1, dv});
            end
            put_attn({dv, 5'h01});
            chk("R2 rnd open", {collecting, cmd_dev}, {1'b1, dv});
            put_word(w0);
            put_word(w1);
            if (lng) begin
                chk("R4 rnd long open", collecting, 1'b1);
                put_word(w2);
                put_word(w3);
            end
            chk("R4 rnd closed", collecting, 1'b0);
            if (bad) begin
                chk("R6 rnd mismatch", {err_pulse, err_code, busy}, {1'b1, 3'd2, 1'b0});
                expect_no_start("R6 rnd no start", D + 1);
            end else begin
                expect_start("R5 rnd", w0[4:0], pack_words(w0, w1, w2, w3, lng));
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule